// File: doc/BRIEF.md
# Stereo Zero-Run Automute Detector

This block watches the sample stream of one stereo DAC pair. When the pair has carried zero on both channels for a long unbroken run of sample periods, the block raises a mute flag and forces the pair's output samples to zero. The run length is 1024 samples by default. The first sample period in which either channel is non-zero clears the mute at once, and that sample goes through to the output unchanged.

The left and right channels share one run counter and one mute state. A design with several DACs places one instance per stereo pair, so every pair is detected and muted on its own. Detection is gated by an enable input, and the block is inactive while the enable is low.

Top module: `zero_run_automute`

## Requirements
- R1: After reset the mute flag is 0, both output samples are 0 and the zero run count is 0.
- R2: While `det_en` is 0, the mute flag stays 0 however many zero samples arrive, and each strobed sample reaches the outputs unchanged.
- R3: With `det_en` at 1, the mute flag rises one clock after the strobe that carries the RUN_LEN-th consecutive zero sample pair. It stays 0 after RUN_LEN-1 such pairs.
- R4: A sample period counts as zero only when the left word and the right word are both exactly 0. A strobe with either word non-zero restarts the run from 0.
- R5: A strobe with either word non-zero clears the mute flag on the next clock. The outputs of that same clock carry that sample unmodified.
- R6: The run counter saturates and does not wrap. The mute flag stays 1 through zero runs far longer than RUN_LEN (3000 samples are tested).
- R7: When `det_en` is dropped, the mute flag falls on the next clock and the run restarts. After `det_en` is raised again, RUN_LEN fresh zero pairs are needed to mute.
- R8: On each strobe the outputs take the input sample one clock later, or 0 while muted. Whenever the mute flag is 1, both outputs are 0.
- R9: Without a strobe, the mute flag, the outputs and the run count hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_en | input | 1 | Zero-run detection enable |
| smp_vld | input | 1 | Sample strobe, one clock per sample period |
| smp_l | input | DATA_W | Signed left sample |
| smp_r | input | DATA_W | Signed right sample |
| mute | output | 1 | Pair muted |
| out_l | output | DATA_W | Gated left sample |
| out_r | output | DATA_W | Gated right sample |

## Verification
Two events can land on one clock edge. The first is the strobe that completes the zero run and sets mute. The second is a drop of the enable or a non-zero sample that clears mute. The bench provokes both collisions:
- It drops `det_en` on the very strobe that would carry the final zero of the run, and expects mute to stay 0.
- It sends a non-zero word on one channel one sample before the run would complete, and expects the run to restart.

A reference model in the bench judges every cycle. The model tracks the run count, the mute state and the output words, and its values are compared with the ports half a clock after each edge.

// File: rtl/zero_run_automute.sv
module zero_run_automute #(
  parameter int DATA_W  = 24,
  parameter int RUN_LEN = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     det_en,
  input  logic                     smp_vld,
  input  logic signed [DATA_W-1:0] smp_l,
  input  logic signed [DATA_W-1:0] smp_r,
  output logic                     mute,
  output logic signed [DATA_W-1:0] out_l,
  output logic signed [DATA_W-1:0] out_r
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] run_cnt;

  wire pair_zero = (smp_l == '0) && (smp_r == '0);
  wire mute_nxt  = det_en && (smp_vld ? (pair_zero && run_cnt >= LAST) : mute);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      mute    <= 1'b0;
      out_l   <= '0;
      out_r   <= '0;
    end else begin
      if (!det_en)
        run_cnt <= '0;
      else if (smp_vld)
        run_cnt <= !pair_zero ? '0 : (run_cnt == FULL ? run_cnt : run_cnt + 1'b1);
      mute <= mute_nxt;
      if (smp_vld) begin
        out_l <= mute_nxt ? '0 : smp_l;
        out_r <= mute_nxt ? '0 : smp_r;
      end
    end
  end
endmodule

// File: rtl/zero_run_automute_chk.sv
module zero_run_automute_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              det_en,
  input logic              smp_vld,
  input logic [DATA_W-1:0] smp_l,
  input logic [DATA_W-1:0] smp_r,
  input logic              mute,
  input logic [DATA_W-1:0] out_l,
  input logic [DATA_W-1:0] out_r
);
  a_r3_rise_on_zero_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute) |-> $past(det_en && smp_vld && smp_l == '0 && smp_r == '0));

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && smp_vld && (smp_l != '0 || smp_r != '0)) |=> !mute);

  a_r5_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && (smp_l != '0 || smp_r != '0)) |=> (out_l == $past(smp_l) && out_r == $past(smp_r)));

  a_r2_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> !mute);

  a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
    mute |-> (out_l == '0 && out_r == '0));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && !smp_vld) |=> ($stable(mute) && $stable(out_l) && $stable(out_r)));
endmodule

bind zero_run_automute zero_run_automute_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .det_en(det_en), .smp_vld(smp_vld),
  .smp_l(smp_l), .smp_r(smp_r), .mute(mute), .out_l(out_l), .out_r(out_r)
);

// File: tb/zero_run_automute_tb_top.sv
module zero_run_automute_tb_top;
  localparam int DW = 24;
  localparam int RL = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic det_en = 1'b0;
  logic smp_vld = 1'b0;
  logic signed [DW-1:0] smp_l = '0, smp_r = '0;
  logic mute;
  logic signed [DW-1:0] out_l, out_r;

  int n_chk = 0, n_err = 0;
  int m_cnt = 0;
  logic m_mute = 1'b0;
  logic signed [DW-1:0] m_l = '0, m_r = '0;

  always #10 clk = ~clk;

  zero_run_automute #(.DATA_W(DW), .RUN_LEN(RL)) dut_i (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .smp_vld(smp_vld),
    .smp_l(smp_l), .smp_r(smp_r), .mute(mute), .out_l(out_l), .out_r(out_r));

  task automatic compare(input string tag);
    n_chk++;
    if (mute !== m_mute || out_l !== m_l || out_r !== m_r) begin
      n_err++;
      $display("FAIL %s: mute=%0b l=%0d r=%0d expected mute=%0b l=%0d r=%0d",
               tag, mute, out_l, out_r, m_mute, m_l, m_r);
    end
  endtask

  task automatic model_step();
    logic z;
    z = (smp_l == 0) && (smp_r == 0);
    if (!det_en) begin
      m_cnt = 0; m_mute = 1'b0;
    end else if (smp_vld) begin
      if (z) begin
        if (m_cnt < RL) m_cnt++;
        m_mute = (m_cnt >= RL);
      end else begin
        m_cnt = 0; m_mute = 1'b0;
      end
    end
    if (smp_vld) begin
      m_l = m_mute ? '0 : smp_l;
      m_r = m_mute ? '0 : smp_r;
    end
  endtask

  task automatic cyc(input logic en, input logic vld, input int l, input int r, input string tag);
    det_en = en; smp_vld = vld; smp_l = DW'(l); smp_r = DW'(r);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic zeros(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 0, 0, tag);
  endtask

  initial begin
    #4000000;
    n_err++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    for (int i = 0; i < 1100; i++) cyc(1'b0, 1'b1, 0, 0, "R2 disabled zeros");
    cyc(1'b0, 1'b1, -5, 7, "R2 disabled pass");

    zeros(RL - 1, "R3 below threshold");
    cyc(1'b0, 1'b1, 0, 0, "R7 enable drop on final zero");
    zeros(RL - 1, "R7 fresh run needed");
    zeros(1, "R3 threshold reached");
    cyc(1'b1, 1'b1, 1234, 0, "R5 left non-zero releases");
    zeros(RL - 1, "R4 run before break");
    cyc(1'b1, 1'b1, 0, -1, "R4 right non-zero breaks run");
    zeros(RL - 1, "R4 restarted run");
    zeros(1, "R3 mute after restart");
    zeros(3000, "R6 saturated run");
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 99, 99, "R9 no strobe hold");
    cyc(1'b1, 1'b1, 0, 42, "R5 right non-zero releases");
    zeros(RL + 5, "R3 mute again");
    cyc(1'b0, 1'b0, 0, 0, "R7 enable drop unmutes");
    zeros(RL - 1, "R7 re-enabled run");
    zeros(1, "R7 mute after re-enable");

    for (int i = 0; i < 30000; i++) begin
      logic v;
      int l, r;
      v = ($urandom % 8) != 0;
      l = 0; r = 0;
      if (($urandom % 1500) == 0) l = int'($urandom % 200) - 100;
      if (($urandom % 1500) == 0) r = int'($urandom % 200) - 100;
      cyc(($urandom % 4000) != 0, v, l, r, "R8 random stream");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule